// File: doc/BRIEF.md
# Wake-Aware System Clock Source Controller

This block decides which oscillator drives the system clock of a low-power controller and produces the processor clock enable. On every wake the controller comes up on the fast RC oscillator. A two-bit policy input then sets when, if ever, it moves to the crystal-derived clock. It can move as soon as the crystal reports ready, only after software has asked and the crystal is ready, or never before the next sleep. The select change is passed through a short handshake chain. A status flag therefore rises only once the new source has really taken over.

The block also divides a 32 MHz base into processor enables for rates of 1, 2, 4, 8, 16 or 32 MHz, set by a speed code. A code outside that set is dropped. A separate latch records the source of the slow 32 kHz timing clock. It starts on the internal RC oscillator after chip reset. Once software picks the crystal or an external clock, that choice stays until the next reset.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the system select is RC (`sys_sel_o`=0), `on_xtal_o`=0, `slow_src_o`=0 (RC), and the speed is code 4 (16 MHz, one enable every 2 cycles).
- R2: While `sleep_i` is high, `sys_sel_o` is 0 one edge later. On the first awake cycle after sleep the select is still 0 (RC), and `cpu_en_o` stays low throughout sleep.
- R3: Policy 0 (automatic): while awake, on RC, with `xtal_rdy_i` high, `sys_sel_o` becomes 1 (crystal) at the next edge.
- R4: Policy 1 (software): the select moves to the crystal only after a one-cycle `sw_req_i` pulse. A pulse given before `xtal_rdy_i` is held pending and takes effect at the edge after ready is seen. Without a request the select stays RC.
- R5: Policies 2 and 3 (hold): the select stays RC during the whole wake period, whatever the ready flag and requests do.
- R6: `on_xtal_o` follows `sys_sel_o` through a handshake of SYNC_STAGES (default 2) registers. It equals the select SYNC_STAGES edges after the select last changed, and still shows the old value one edge after a change.
- R7: A legal speed code k (0..5) written with `speed_wr_i` gives one `cpu_en_o` pulse every 2^(5-k) cycles, a rate of 2^k MHz from a 32 MHz base.
- R8: Speed codes 6 and 7 are ignored and the previous rate stays.
- R9: `slow_src_o` codes: 0 internal RC, 1 crystal, 2 external clock. A write of 1 or 2 while on RC latches it. After that every write is ignored until reset, and code 3 is never taken.
- R10: A pending software request is dropped by sleep, so after the next wake the select stays RC without a new request.
- R11: Once on the crystal, the select stays there until sleep, even if the policy changes or the ready flag drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (32 MHz reference domain) |
| rst_n | input | 1 | Active-low full chip reset |
| sleep_i | input | 1 | High while the device is asleep |
| xtal_rdy_i | input | 1 | Crystal-derived clock is stable |
| sw_req_i | input | 1 | One-cycle software request to switch to the crystal |
| policy_i | input | 2 | 0 automatic, 1 software, 2/3 hold on RC |
| speed_wr_i | input | 1 | Write strobe for the speed code |
| speed_code_i | input | 3 | CPU rate code k, rate 2^k MHz, 0..5 legal |
| slow_wr_i | input | 1 | Write strobe for the slow-source choice |
| slow_code_i | input | 2 | Slow source: 0 RC, 1 crystal, 2 external |
| sys_sel_o | output | 1 | System clock select: 0 RC, 1 crystal |
| on_xtal_o | output | 1 | Switched-over status after the handshake |
| cpu_en_o | output | 1 | Processor clock enable |
| slow_src_o | output | 2 | Latched slow timing source |

## Verification
Every policy is paired with three request patterns: no request, a request before the crystal is ready, and a request after it is ready. Together these separate the automatic, software and hold behaviours and show whether an early request is kept or lost. The speed sweep writes all eight codes in turn and counts enables over a fixed 64-cycle window. The count separates each legal divide ratio from its neighbours and shows that illegal codes leave the rate alone. Wake-after-sleep sequences check the RC restart, the dropping of a pending request and the lag of the status flag behind the select. Slow-source writes tried in several orders show whether the first legal choice locks.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   localparam logic [1:0] POL_AUTO = 2'd0;
   localparam logic [1:0] POL_SOFT = 2'd1;

   localparam logic [1:0] SLOW_RC   = 2'd0;
   localparam logic [1:0] SLOW_XTAL = 2'd1;
   localparam logic [1:0] SLOW_EXT  = 2'd2;

   localparam logic SRC_RC   = 1'b0;
   localparam logic SRC_XTAL = 1'b1;
endpackage

// File: rtl/clk_sel_sync.sv
module clk_sel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   output logic status_o
);
   localparam int CW = $clog2(STAGES + 1);

   generate
      if (STAGES == 1) begin : g_single
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= 1'b0;
            else        st_q <= sel_i;
         end
         assign status_o = st_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], sel_i};
         end
         assign status_o = sh_q[STAGES-1];
      end
   endgenerate

   // settle window tracker for the handshake check
   logic          prev_q;
   logic [CW-1:0] calm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         calm_q <= '0;
      end else begin
         prev_q <= sel_i;
         if (sel_i != prev_q)           calm_q <= '0;
         else if (calm_q != CW'(STAGES)) calm_q <= calm_q + 1'b1;
      end
   end

   // R6
   settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == prev_q && calm_q >= CW'(STAGES - 1)) |-> status_o == sel_i);
endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div #(
   parameter int SPEED_W    = 3,
   parameter int NUM_SPEEDS = 6,
   parameter int RST_SPEED  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               wr_i,
   input  logic [SPEED_W-1:0] code_i,
   output logic               en_o
);
   localparam int CNT_W = (NUM_SPEEDS > 1) ? NUM_SPEEDS - 1 : 1;

   function automatic logic [CNT_W-1:0] lim_of(input logic [SPEED_W-1:0] c);
      lim_of = CNT_W'((32'd1 << (NUM_SPEEDS - 1 - int'(c))) - 32'd1);
   endfunction

   logic [CNT_W-1:0] lim_q, cnt_q;
   logic             legal;

   assign legal = 32'(code_i) < 32'(NUM_SPEEDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= lim_of(SPEED_W'(RST_SPEED));
         cnt_q <= '0;
      end else if (wr_i && legal) begin
         lim_q <= lim_of(code_i);
         cnt_q <= '0;
      end else if (cnt_q == lim_q) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign en_o = run_i && (cnt_q == lim_q);

   // R8
   bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !legal) |=> $stable(lim_q));
   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);
endmodule

// File: rtl/slow_src_latch.sv
module slow_src_latch (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [1:0] code_i,
   output logic [1:0] src_o
);
   import sysclk_pkg::*;

   logic [1:0] src_q;
   logic       take;

   assign take = wr_i && (src_q == SLOW_RC) &&
                 (code_i == SLOW_XTAL || code_i == SLOW_EXT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    src_q <= SLOW_RC;
      else if (take) src_q <= code_i;
   end

   assign src_o = src_q;

   // R9
   lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q != SLOW_RC) |=> $stable(src_q));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
   parameter int SYNC_STAGES = 2,
   parameter int SPEED_W     = 3,
   parameter int NUM_SPEEDS  = 6,
   parameter int RST_SPEED   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_i,
   input  logic               xtal_rdy_i,
   input  logic               sw_req_i,
   input  logic [1:0]         policy_i,
   input  logic               speed_wr_i,
   input  logic [SPEED_W-1:0] speed_code_i,
   input  logic               slow_wr_i,
   input  logic [1:0]         slow_code_i,
   output logic               sys_sel_o,
   output logic               on_xtal_o,
   output logic               cpu_en_o,
   output logic [1:0]         slow_src_o
);
   import sysclk_pkg::*;

   initial begin
      stages_ok_chk: assert (SYNC_STAGES >= 1);
      speeds_ok_chk: assert (NUM_SPEEDS >= 1 && NUM_SPEEDS <= (1 << SPEED_W));
      rst_speed_chk: assert (RST_SPEED >= 0 && RST_SPEED < NUM_SPEEDS);
   end

   logic sel_q, pend_q, want_soft, go;

   assign want_soft = pend_q | sw_req_i;

   always_comb begin
      case (policy_i)
         POL_AUTO: go = 1'b1;
         POL_SOFT: go = want_soft;
         default:  go = 1'b0;
      endcase
      go = go & ~sleep_i & xtal_rdy_i & (sel_q == SRC_RC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= SRC_RC;
         pend_q <= 1'b0;
      end else if (sleep_i) begin
         sel_q  <= SRC_RC;
         pend_q <= 1'b0;
      end else begin
         sel_q  <= sel_q | go;
         pend_q <= want_soft & ~go & ~sel_q;
      end
   end

   assign sys_sel_o = sel_q;

   clk_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel_q),
      .status_o (on_xtal_o)
   );

   cpu_clk_div #(
      .SPEED_W    (SPEED_W),
      .NUM_SPEEDS (NUM_SPEEDS),
      .RST_SPEED  (RST_SPEED)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (~sleep_i),
      .wr_i   (speed_wr_i),
      .code_i (speed_code_i),
      .en_o   (cpu_en_o)
   );

   slow_src_latch u_slow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (slow_wr_i),
      .code_i (slow_code_i),
      .src_o  (slow_src_o)
   );

   // R2
   sleep_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> !sys_sel_o);
   // R3
   auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && xtal_rdy_i && policy_i == POL_AUTO) |=> sys_sel_o);
   // R4
   soft_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == POL_SOFT && !sys_sel_o && !pend_q && !sw_req_i) |=> !sys_sel_o);
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i[1] && !sys_sel_o) |=> !sys_sel_o);
   // R11
   stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_sel_o && !sleep_i) |=> sys_sel_o);
endmodule

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       sleep_i, xtal_rdy_i, sw_req_i, speed_wr_i, slow_wr_i;
   logic [1:0] policy_i, slow_code_i;
   logic [2:0] speed_code_i;
   logic       sys_sel_o, on_xtal_o, cpu_en_o;
   logic [1:0] slow_src_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   sysclk_switch uut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .xtal_rdy_i(xtal_rdy_i),
      .sw_req_i(sw_req_i), .policy_i(policy_i), .speed_wr_i(speed_wr_i),
      .speed_code_i(speed_code_i), .slow_wr_i(slow_wr_i),
      .slow_code_i(slow_code_i), .sys_sel_o(sys_sel_o), .on_xtal_o(on_xtal_o),
      .cpu_en_o(cpu_en_o), .slow_src_o(slow_src_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_en(output int n);
      n = 0;
      repeat (64) begin
         @(negedge clk);
         if (cpu_en_o) n++;
      end
   endtask

   task automatic put_speed(input int code);
      speed_code_i = 3'(code);
      speed_wr_i   = 1'b1;
      tick(1);
      speed_wr_i   = 1'b0;
   endtask

   task automatic put_slow(input int code);
      slow_code_i = 2'(code);
      slow_wr_i   = 1'b1;
      tick(1);
      slow_wr_i   = 1'b0;
      tick(1);
   endtask

   task automatic nap_and_wake(input int pol);
      sleep_i    = 1'b1;
      xtal_rdy_i = 1'b0;
      tick(4);
      policy_i = 2'(pol);
      sleep_i  = 1'b0;
      tick(1);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, cur, exp;
      rst_n = 1'b0; sleep_i = 1'b0; xtal_rdy_i = 1'b0; sw_req_i = 1'b0;
      policy_i = 2'd2; speed_wr_i = 1'b0; speed_code_i = '0;
      slow_wr_i = 1'b0; slow_code_i = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 sel", int'(sys_sel_o), 0);
      chk("R1 status", int'(on_xtal_o), 0);
      chk("R1 slow", int'(slow_src_o), 0);
      count_en(n);
      chk("R1 default rate", n, 32);

      // R7 R8 speed sweep
      cur = 4;
      for (int k = 0; k < 8; k++) begin
         put_speed(k);
         if (k < 6) cur = k;
         exp = 2 << cur;
         count_en(n);
         if (k < 6) chk("R7 rate", n, exp);
         else       chk("R8 illegal code", n, exp);
      end
      sleep_i = 1'b1;
      count_en(n);
      chk("R2 no enable asleep", n, 0);
      sleep_i = 1'b0;

      // R3 R4 R5 R6 policy x request-timing sweep
      for (int p = 0; p < 4; p++) begin
         for (int m = 0; m < 3; m++) begin
            bit want;
            want = (p == 0) || (p == 1 && m != 0);
            nap_and_wake(p);
            chk("R2 wake on RC", int'(sys_sel_o), 0);
            chk("R2 wake status", int'(on_xtal_o), 0);
            if (m == 1) begin
               sw_req_i = 1'b1;
               tick(1);
               sw_req_i = 1'b0;
               tick(4);
               chk("R4 pending waits", int'(sys_sel_o), 0);
            end
            xtal_rdy_i = 1'b1;
            tick(1);
            if (p == 0 && m == 0) chk("R6 status lags", int'(on_xtal_o), 0);
            if (m == 2) begin
               chk("R4 no switch before req", int'(sys_sel_o), int'(p == 0));
               sw_req_i = 1'b1;
               tick(1);
               sw_req_i = 1'b0;
            end
            if (p == 0)      chk("R3 auto switch", int'(sys_sel_o), 1);
            else if (p == 1) chk("R4 soft switch", int'(sys_sel_o), int'(want));
            else             chk("R5 hold RC", int'(sys_sel_o), 0);
            tick(2);
            chk("R6 status settles", int'(on_xtal_o), int'(want));
            tick(10);
            chk("R5 R11 steady", int'(sys_sel_o), int'(want));
         end
      end

      // R11 policy change and ready loss after switching
      nap_and_wake(0);
      xtal_rdy_i = 1'b1;
      tick(2);
      policy_i   = 2'd2;
      xtal_rdy_i = 1'b0;
      tick(6);
      chk("R11 stays on crystal", int'(sys_sel_o), 1);
      sleep_i = 1'b1;
      tick(1);
      chk("R2 sleep forces RC", int'(sys_sel_o), 0);

      // R10 pending request lost across sleep
      nap_and_wake(1);
      sw_req_i = 1'b1;
      tick(1);
      sw_req_i = 1'b0;
      tick(2);
      nap_and_wake(1);
      xtal_rdy_i = 1'b1;
      tick(6);
      chk("R10 request dropped", int'(sys_sel_o), 0);

      // R9 slow source latch
      put_slow(3);
      chk("R9 code 3 ignored", int'(slow_src_o), 0);
      put_slow(2);
      chk("R9 external latched", int'(slow_src_o), 2);
      put_slow(1);
      chk("R9 later write ignored", int'(slow_src_o), 2);
      put_slow(0);
      chk("R9 back to RC ignored", int'(slow_src_o), 2);
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      chk("R1 R9 reset clears slow", int'(slow_src_o), 0);
      put_slow(1);
      chk("R9 crystal latched", int'(slow_src_o), 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule